// File: doc/BRIEF.md
# N-way set-associative write-back data cache

This block sits between a processor load/store port and a word-serial main-memory port. It keeps copies of recently used memory blocks in a small set-associative store. A processor address is split into three fields: the tag, the set index and the word offset. The index selects a set. All tags of that set are compared with the request's tag in the same cycle. A request that hits completes in the cycle it is presented. A read returns the cached word, and a write updates the cached word and marks its block as modified.

On a miss, the processor stalls while the controller frees a way in the selected set. An invalid way is always used first. Otherwise the way that was filled earliest in that set is evicted. If the evicted block was modified, its words are first written back to memory one at a time. The new block is then read in one word at a time. After that, the original access is served as a hit.

Write misses allocate a line: the block is fetched, the new word is merged into it, and the block is marked modified. Memory is written only when a modified block leaves the cache.

Top module: `assoc_wb_cache`

## Requirements
- R1: After reset every line is invalid, `ready_o` and `mem_req_o` are low, and the first access to any address is a miss.
- R2: A word address is laid out as {tag, index, offset}. The offset is the low log2(WORDS) bits, and the index is the next log2(SETS) bits above it.
- R3: A request that hits raises `ready_o` in the same cycle it is presented and causes no memory traffic. A read hit returns the most recently written value of that address.
- R4: A miss fetches the whole block with WORDS memory reads. The reads go to the block-aligned addresses in ascending offset order. The original access then completes.
- R5: When the selected set has an invalid way, the lowest-numbered invalid way is filled, and no valid block is evicted.
- R6: In a full set, the victim is the way filled earliest (first-in-first-out). Each set's order advances only when a block is filled into that set. Hits do not change the order.
- R7: A processor write marks the written block as modified. A write hit itself performs no memory write.
- R8: Evicting a modified block writes all WORDS of its words to their original addresses, in ascending order, before the refill starts.
- R9: Evicting an unmodified block performs no memory writes.
- R10: A write miss first refills the block, then merges the written word and marks the block modified.
- R11: A memory request keeps its address, direction and write data unchanged until `mem_ack_i` is seen. Exactly one word moves per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Processor request, held with stable fields until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Access completes on this clock edge |
| rdata_o | output | DATA_W | Read data, valid while `ready_o` is high |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | 1 = memory write (write-back), 0 = read (refill) |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write-back data |
| mem_ack_i | input | 1 | Memory accepted/delivered one word this cycle |
| mem_rdata_i | input | DATA_W | Refill data, valid with `mem_ack_i` |

## Verification
Two events can land on the same victim way in consecutive cycles: a write hit that sets a block's modified flag, and an eviction of that same way by the next miss in the set. The bench first drives the set's replacement order so that the way it is about to write is next in line. It then writes into that way and immediately presents a miss to the same set. The result is judged at the memory port. There must be exactly one full block of write-backs, and the freshly written word must be in memory at its original address. A full address sweep of writes followed by reads then compares every returned word with a value computed arithmetically in the bench.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_WBACK  = 2'd1,
    ST_REFILL = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int TAG_W = 3,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_o,
  output logic [WAYS-1:0]            valid_o,
  output logic [WAYS-1:0]            dirty_o,
  output logic [WAYS-1:0][TAG_W-1:0] tags_o,
  input  logic                       fill_i,
  input  logic [WAY_W-1:0]           fill_way_i,
  input  logic                       mark_i,
  input  logic [WAY_W-1:0]           mark_way_i
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (fill_i) begin
        valid_q[idx_i][fill_way_i] <= 1'b1;
        dirty_q[idx_i][fill_way_i] <= 1'b0;
      end
      if (mark_i) dirty_q[idx_i][mark_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i][fill_way_i] <= tag_i;
  end

  // parallel compare across the selected set
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tags_o[w]  = tag_q[idx_i][w];
    assign valid_o[w] = valid_q[idx_i][w];
    assign dirty_o[w] = dirty_q[idx_i][w];
    assign hit_o[w]   = valid_q[idx_i][w] && (tag_q[idx_i][w] == tag_i);
  end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem_q [SETS][WAYS][WORDS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[idx_i][wr_way_i][wr_off_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[idx_i][rd_way_i][rd_off_i];
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
  parameter int WAYS = 2,
  parameter int SETS = 4,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] victim_o
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] ptr_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv_i) begin
      ptr_q[idx_i] <= (ptr_q[idx_i] == LAST_WAY) ? '0 : ptr_q[idx_i] + 1'b1;
    end
  end

  // lowest invalid way wins, else oldest fill
  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = ptr_q[idx_i];
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/assoc_wb_cache.sv
module assoc_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int WORDS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  ctrl_state_e state_q, state_d;
  logic [WAY_W-1:0] vic_q, vic_d;
  logic [TAG_W-1:0] vic_tag_q, vic_tag_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] req_off;
  assign {req_tag, req_idx, req_off} = addr_i;

  logic [WAYS-1:0]            hit_vec, valid_vec, dirty_vec;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAY_W-1:0]           hit_way, victim;
  logic                       hit, lookup, refill_ack, last_word;
  logic                       fill, mark;
  logic [WAY_W-1:0]           rd_way, wr_way;
  logic [OFF_W-1:0]           rd_off, wr_off;
  logic [DATA_W-1:0]          rd_data, wr_data;
  logic                       wr_en;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit        = |hit_vec;
  assign lookup     = (state_q == ST_LOOKUP);
  assign ready_o    = lookup && req_i && hit;
  assign rdata_o    = rd_data;
  assign last_word  = (cnt_q == LAST_OFF);
  assign refill_ack = (state_q == ST_REFILL) && mem_ack_i;
  assign fill       = refill_ack && last_word;
  assign mark       = ready_o && we_i;

  assign rd_way  = lookup ? hit_way : vic_q;
  assign rd_off  = lookup ? req_off : cnt_q;
  assign wr_en   = refill_ack || mark;
  assign wr_way  = refill_ack ? vic_q : hit_way;
  assign wr_off  = refill_ack ? cnt_q : req_off;
  assign wr_data = refill_ack ? mem_rdata_i : wdata_i;

  assign mem_req_o   = (state_q == ST_WBACK) || (state_q == ST_REFILL);
  assign mem_we_o    = (state_q == ST_WBACK);
  assign mem_addr_o  = {(state_q == ST_WBACK) ? vic_tag_q : req_tag, req_idx, cnt_q};
  assign mem_wdata_o = rd_data;

  cache_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) i_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (req_idx),
    .tag_i      (req_tag),
    .hit_o      (hit_vec),
    .valid_o    (valid_vec),
    .dirty_o    (dirty_vec),
    .tags_o     (set_tags),
    .fill_i     (fill),
    .fill_way_i (vic_q),
    .mark_i     (mark),
    .mark_way_i (hit_way)
  );

  cache_data_store #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) i_data (
    .clk_i     (clk_i),
    .idx_i     (req_idx),
    .rd_way_i  (rd_way),
    .rd_off_i  (rd_off),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_way_i  (wr_way),
    .wr_off_i  (wr_off),
    .wr_data_i (wr_data)
  );

  cache_victim_sel #(.WAYS(WAYS), .SETS(SETS)) i_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_i    (req_idx),
    .valid_i  (valid_vec),
    .adv_i    (fill),
    .victim_o (victim)
  );

  always_comb begin
    state_d   = state_q;
    vic_d     = vic_q;
    vic_tag_d = vic_tag_q;
    cnt_d     = cnt_q;
    unique case (state_q)
      ST_LOOKUP: begin
        if (req_i && !hit) begin
          vic_d     = victim;
          vic_tag_d = set_tags[victim];
          cnt_d     = '0;
          state_d   = (valid_vec[victim] && dirty_vec[victim]) ? ST_WBACK : ST_REFILL;
        end
      end
      ST_WBACK: begin
        if (mem_ack_i) begin
          cnt_d = cnt_q + 1'b1;
          if (last_word) begin
            cnt_d   = '0;
            state_d = ST_REFILL;
          end
        end
      end
      ST_REFILL: begin
        if (mem_ack_i) begin
          cnt_d = cnt_q + 1'b1;
          if (last_word) begin
            cnt_d   = '0;
            state_d = ST_LOOKUP;
          end
        end
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_LOOKUP;
      vic_q     <= '0;
      vic_tag_q <= '0;
      cnt_q     <= '0;
    end else begin
      state_q   <= state_d;
      vic_q     <= vic_d;
      vic_tag_q <= vic_tag_d;
      cnt_q     <= cnt_d;
    end
  end
endmodule

// File: rtl/assoc_wb_cache_chk.sv
module assoc_wb_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  assert_ready_needs_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> req_i);

  assert_stall_during_miss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);

  assert_miss_starts_traffic_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(req_i && !ready_o));

  assert_burst_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (mem_addr_o[OFF_W-1:0] == '0));

  assert_req_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_wdata_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ack_i) |=> $stable(mem_wdata_o));
endmodule

bind assoc_wb_cache assoc_wb_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/test_assoc_wb_cache.sv
`timescale 1ns/1ps
module test_assoc_wb_cache;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NW = 256;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          ready_o;
  logic [DW-1:0] rdata_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_ack_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;

  always #10 clk_i = ~clk_i;

  assoc_wb_cache i_assoc_wb_cache (.*);

  logic [DW-1:0] ram     [NW];
  logic [DW-1:0] ref_mem [NW];
  logic [AW-1:0] rd_log [8];
  logic [AW-1:0] wr_log [8];
  int rd_cnt = 0, wr_cnt = 0;
  int checks = 0, errors = 0;

  function automatic logic [DW-1:0] init_word(int a);
    return (32'(a) * 32'h0101_0101) ^ 32'hA500_0000;
  endfunction

  // memory: acknowledges every other cycle while requested
  always @(negedge clk_i) begin
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i = 1'b1;
      if (mem_we_o) begin
        ram[mem_addr_o] = mem_wdata_o;
        wr_log[wr_cnt % 8] = mem_addr_o;
        wr_cnt++;
      end else begin
        mem_rdata_i = ram[mem_addr_o];
        rd_log[rd_cnt % 8] = mem_addr_o;
        rd_cnt++;
      end
    end else begin
      mem_ack_i = 1'b0;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int cyc);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    #1;
    cyc = 0;
    while (!ready_o && cyc < 2000) begin
      @(negedge clk_i); #1; cyc++;
    end
    rd = rdata_o;
    if (w) ref_mem[a] = d;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  // read with data check, returns latency and traffic deltas
  task automatic rd_chk(input logic [AW-1:0] a, input string rq,
                        output int cyc, output int drd, output int dwr);
    logic [DW-1:0] v;
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b0, a, '0, v, cyc);
    drd = rd_cnt - r0; dwr = wr_cnt - w0;
    check(v == ref_mem[a], rq, $sformatf("read data @%h", a), v, ref_mem[a]);
  endtask

  task automatic wr_do(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output int cyc, output int drd, output int dwr);
    logic [DW-1:0] v;
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, a, d, v, cyc);
    drd = rd_cnt - r0; dwr = wr_cnt - w0;
  endtask

  initial begin
    int cyc, drd, dwr;
    bit ok;
    for (int a = 0; a < NW; a++) begin
      ram[a] = init_word(a);
      ref_mem[a] = init_word(a);
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(ready_o == 1'b0, "R1", "ready after reset", 32'(ready_o), 0);
    check(mem_req_o == 1'b0, "R1", "mem_req after reset", 32'(mem_req_o), 0);

    // R2: 0x2D = tag 1, index 1, offset 5 -> burst 0x28..0x2F
    rd_chk(8'h2D, "R4", cyc, drd, dwr);
    check(cyc > 0, "R1", "first access misses", 32'(cyc), 1);
    check(drd == 8 && dwr == 0, "R4", "refill read count", 32'(drd), 8);
    ok = 1'b1;
    for (int k = 0; k < 8; k++) if (rd_log[k] != 8'(8'h28 + k)) ok = 1'b0;
    check(ok, "R2", "refill address order", 32'(rd_log[0]), 32'h28);
    rd_chk(8'h2A, "R3", cyc, drd, dwr);
    check(cyc == 0 && drd == 0, "R3", "hit latency same block", 32'(cyc), 0);

    // set 0: index bits [4:3] = 0
    rd_chk(8'h00, "R4", cyc, drd, dwr);
    check(drd == 8, "R4", "miss 0x00 reads", 32'(drd), 8);
    wr_do(8'h03, 32'hDEAD_0003, cyc, drd, dwr);
    check(cyc == 0 && dwr == 0, "R7", "write hit no mem write", 32'(dwr), 0);
    rd_chk(8'h03, "R3", cyc, drd, dwr);
    check(cyc == 0, "R3", "read after write hit", 32'(cyc), 0);

    rd_chk(8'h20, "R5", cyc, drd, dwr);
    check(drd == 8 && dwr == 0, "R5", "second way filled, no eviction", 32'(dwr), 0);
    rd_chk(8'h00, "R5", cyc, drd, dwr);
    check(cyc == 0, "R5", "0x00 kept in way 0", 32'(cyc), 0);

    // FIFO: 0x00 was filled first and is evicted despite recent hit
    rd_chk(8'h40, "R6", cyc, drd, dwr);
    check(dwr == 8 && drd == 8, "R8", "dirty eviction writes block", 32'(dwr), 8);
    ok = 1'b1;
    for (int k = 0; k < 8; k++) if (wr_log[k] != 8'(k)) ok = 1'b0;
    check(ok, "R8", "write-back order (R11)", 32'(wr_log[0]), 0);
    check(ram[3] == 32'hDEAD_0003, "R8", "written-back word", ram[3], 32'hDEAD_0003);
    rd_chk(8'h20, "R6", cyc, drd, dwr);
    check(cyc == 0, "R6", "0x20 survives (FIFO not LRU)", 32'(cyc), 0);

    rd_chk(8'h00, "R9", cyc, drd, dwr);
    check(drd == 8 && dwr == 0, "R9", "clean eviction no writes", 32'(dwr), 0);

    // write miss: evicts 0x40 (clean)
    wr_do(8'h63, 32'hBEEF_0063, cyc, drd, dwr);
    check(cyc > 0 && drd == 8 && dwr == 0, "R10", "write miss refills", 32'(drd), 8);
    check(ram[8'h63] == init_word(8'h63), "R10", "memory untouched on write miss",
          ram[8'h63], init_word(8'h63));
    rd_chk(8'h63, "R10", cyc, drd, dwr);
    check(cyc == 0, "R10", "merged word hits", 32'(cyc), 0);
    rd_chk(8'h62, "R10", cyc, drd, dwr);
    rd_chk(8'h80, "R9", cyc, drd, dwr);
    check(dwr == 0, "R9", "evict clean 0x00", 32'(dwr), 0);
    rd_chk(8'hA0, "R10", cyc, drd, dwr);
    check(dwr == 8, "R10", "allocated block dirty", 32'(dwr), 8);
    check(ram[8'h63] == 32'hBEEF_0063, "R10", "merged word written back",
          ram[8'h63], 32'hBEEF_0063);

    // write hit to next victim, then immediate miss in same set
    wr_do(8'h84, 32'hC0DE_0084, cyc, drd, dwr);
    check(cyc == 0 && dwr == 0, "R7", "write hit next victim", 32'(cyc), 0);
    rd_chk(8'hC0, "R8", cyc, drd, dwr);
    check(dwr == 8, "R8", "back-to-back dirty eviction", 32'(dwr), 8);
    check(ram[8'h84] == 32'hC0DE_0084, "R8", "fresh word in memory",
          ram[8'h84], 32'hC0DE_0084);

    // sweep: write every address, then read every address
    for (int a = 0; a < NW; a++) begin
      wr_do(8'(a), {8'(a), ~8'(a), 8'(a) ^ 8'h5A, 8'h3C}, cyc, drd, dwr);
      check(drd == 0 || drd == 8, "R4", "sweep write traffic", 32'(drd), 8);
    end
    for (int a = 0; a < NW; a++) begin
      rd_chk(8'(a), "R3", cyc, drd, dwr);
      check((dwr % 8) == 0, "R8", "sweep write-back granularity", 32'(dwr), 8);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule